// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Core

This block keeps calendar time for a chip: seconds, minutes, hours, day of week, day of month, month and a two-digit year. It also holds an alarm time of seconds, minutes and hours. A one-cycle pulse on `tick_1hz` advances the time by one second. The new time takes month lengths and leap years into account. A host reaches every byte through a small address/data port: one write strobe, one read strobe and a registered read result.

A control byte sets how the time bytes are read. They can be BCD or plain binary, and the hours can use a 24-hour or a 12-hour count with a PM flag. The mode can be changed while the block runs. The same byte holds a freeze bit, so the host can load a new time without an update landing halfway through. It also holds two interrupt enables.

A status byte reports when an update is running. A flag byte holds two sticky events, alarm match and update ended, and reading it clears them. Each event drives its own interrupt request line, gated by its enable.

Top module: `rtc_core`

## Requirements
- R1: After reset, the time bytes read as follows: seconds, minutes and hours 0x00; day of week, day of month and month 0x01; year 0x00. The alarm bytes read 0x00, the control byte reads 0x02, and the flag byte and the status byte read 0x00.
- R2: The address map is fixed. Addresses 0 to 9 hold seconds, seconds alarm, minutes, minutes alarm, hours, hours alarm, day of week, day of month, month and year. Address 10 is status, 11 is control and 12 is flags. A read strobe returns the addressed byte on `host_rdata` after the next clock edge. Without an update or a write, the time bytes hold their value.
- R3: While control bit 7 (freeze) is 1, a tick starts no update and the time bytes do not change.
- R4: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 (24-hour count) and carry into the day. Day of week counts 1 to 7 and then returns to 1.
- R5: Day of month wraps to 1 after the last day of the month. That last day is 30 for months 4, 6, 9 and 11, and 31 for the other months. For month 2 it is 29 when year mod 4 = 0 and 28 otherwise. Month wraps from 12 to 1 and increments the year, and year 99 wraps to 0.
- R6: Control bit 2 selects the encoding of every time and alarm byte: 0 is BCD and 1 is binary. For example, 9 seconds becomes 0x10 in BCD and 0x0A in binary.
- R7: Status bit 7 reads as 1 for exactly the one cycle after a tick that starts an update, and 0 otherwise. Status bits 6 to 0 read as 0, and writes to the status byte have no effect.
- R8: With control bit 1 = 0 (12-hour), hours byte bit 7 is the PM flag and the hour counts 12, 1, ..., 11. The sequences are 11 AM to 12 PM, 12 PM to 1 PM, and 11 PM to 12 AM.
- R9: Flag bit 4 (update ended) is set two cycles after an accepted tick. `irq_update` equals flag bit 4 AND control bit 4. A flag read clears the flags, but a flag being set in the same cycle wins, and the read then returns the value before the set.
- R10: Flag bit 5 (alarm) is set when, after an update, the seconds, minutes and hours bytes all equal their alarm bytes. `irq_alarm` equals flag bit 5 AND control bit 5.
- R11: A host write to a time byte in the cycle the update is applied overrides the new value of that byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| host_addr | input | ADDR_W | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; reading the flag byte clears it |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq_alarm | output | 1 | Alarm interrupt request |
| irq_update | output | 1 | Update-ended interrupt request |

## Verification
Two pairs of functions can fall in the same clock cycle. The first pair is the read-clear of the flag byte and the setting of the update-ended flag. The bench issues the flag read exactly two cycles after a tick. It expects the old, empty byte on that read and finds the flag still set on the next read. The second pair is a host write to the seconds byte and the one-second update. The bench aims the write at the cycle after the tick and expects the written seconds with the minutes still carried forward.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int A_SEC    = 0;
    localparam int A_SEC_AL = 1;
    localparam int A_MIN    = 2;
    localparam int A_MIN_AL = 3;
    localparam int A_HOUR   = 4;
    localparam int A_HR_AL  = 5;
    localparam int A_WDAY   = 6;
    localparam int A_MDAY   = 7;
    localparam int A_MON    = 8;
    localparam int A_YEAR   = 9;
    localparam int A_STAT   = 10;
    localparam int A_CTRL   = 11;
    localparam int A_FLAGS  = 12;

    localparam int B_FREEZE = 7;
    localparam int B_AL_EN  = 5;
    localparam int B_UP_EN  = 4;
    localparam int B_BINARY = 2;
    localparam int B_H24    = 1;

    localparam int N_FLAGS  = 2;
    localparam int F_UPD    = 0;
    localparam int F_ALM    = 1;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
    } rtc_alarm_t;

    localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                       wday: 8'h01, mday: 8'h01, mon: 8'h01,
                                       year: 8'h00};
    localparam logic [7:0] CTRL_RST = 8'h02;

    function automatic int to_bin(input logic [7:0] v, input logic binary);
        if (binary) return int'(v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] from_bin(input int v, input logic binary);
        if (binary) return 8'(v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int hour_to24(input logic [7:0] b, input logic binary,
                                     input logic h24);
        int h;
        if (h24) return to_bin(b, binary);
        h = to_bin({1'b0, b[6:0]}, binary);
        if (h == 12) h = 0;
        return b[7] ? h + 12 : h;
    endfunction

    function automatic logic [7:0] hour_from24(input int h, input logic binary,
                                               input logic h24);
        int h12;
        logic [7:0] enc;
        if (h24) return from_bin(h, binary);
        h12 = h % 12;
        if (h12 == 0) h12 = 12;
        enc = from_bin(h12, binary);
        return {(h >= 12), enc[6:0]};
    endfunction

    function automatic int month_len(input int mon, input int year);
        case (mon)
            2:              return (year % 4 == 0) ? 29 : 28;
            4, 6, 9, 11:    return 30;
            default:        return 31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      binary,
    input  logic      h24,
    output rtc_time_t nxt
);
    int s, m, h, wd, md, mo, yr;
    logic c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        s     = to_bin(cur.sec, binary) + 1;
        c_min = (s > 59);
        if (c_min) s = 0;

        m    = to_bin(cur.min, binary) + (c_min ? 1 : 0);
        c_hr = c_min && (m > 59);
        if (c_hr) m = 0;

        h     = hour_to24(cur.hour, binary, h24) + (c_hr ? 1 : 0);
        c_day = c_hr && (h > 23);
        if (c_day) h = 0;

        wd = to_bin(cur.wday, binary) + (c_day ? 1 : 0);
        if (c_day && wd > 7) wd = 1;

        yr    = to_bin(cur.year, binary);
        mo    = to_bin(cur.mon, binary);
        md    = to_bin(cur.mday, binary) + (c_day ? 1 : 0);
        c_mon = c_day && (md > month_len(mo, yr));
        if (c_mon) md = 1;

        mo   = mo + (c_mon ? 1 : 0);
        c_yr = c_mon && (mo > 12);
        if (c_yr) mo = 1;

        yr = yr + (c_yr ? 1 : 0);
        if (yr > 99) yr = 0;

        nxt.sec  = from_bin(s, binary);
        nxt.min  = from_bin(m, binary);
        nxt.hour = hour_from24(h, binary, h24);
        nxt.wday = from_bin(wd, binary);
        nxt.mday = from_bin(md, binary);
        nxt.mon  = from_bin(mo, binary);
        nxt.year = from_bin(yr, binary);
    end
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flag_o[g] <= 1'b0;
            else if (set_i[g])   flag_o[g] <= 1'b1;
            else if (clr_i)      flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq_alarm,
    output logic              irq_update
);
    rtc_time_t    time_q, nxt_time;
    rtc_alarm_t   alarm_q;
    logic [7:0]   ctrl_q;
    logic         upd_q, chk_q;
    logic         alarm_hit;
    logic [N_FLAGS-1:0] flag_set, flags;
    logic         flag_clr;
    logic [7:0]   rd_mux;
    int           addr_i;

    assign addr_i = int'(host_addr);

    rtc_advance u_adv (
        .cur    (time_q),
        .binary (ctrl_q[B_BINARY]),
        .h24    (ctrl_q[B_H24]),
        .nxt    (nxt_time)
    );

    // update sequence: start, apply, compare
    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q <= 1'b0;
            chk_q <= 1'b0;
        end else begin
            upd_q <= tick_1hz && !ctrl_q[B_FREEZE] && !upd_q;
            chk_q <= upd_q;
        end
    end

    // register file; host write after update so it wins per byte
    always_ff @(posedge clk) begin
        if (rst) begin
            time_q  <= TIME_RST;
            alarm_q <= '0;
            ctrl_q  <= CTRL_RST;
        end else begin
            if (upd_q) time_q <= nxt_time;
            if (host_wr) begin
                case (addr_i)
                    A_SEC:    time_q.sec   <= host_wdata;
                    A_SEC_AL: alarm_q.sec  <= host_wdata;
                    A_MIN:    time_q.min   <= host_wdata;
                    A_MIN_AL: alarm_q.min  <= host_wdata;
                    A_HOUR:   time_q.hour  <= host_wdata;
                    A_HR_AL:  alarm_q.hour <= host_wdata;
                    A_WDAY:   time_q.wday  <= host_wdata;
                    A_MDAY:   time_q.mday  <= host_wdata;
                    A_MON:    time_q.mon   <= host_wdata;
                    A_YEAR:   time_q.year  <= host_wdata;
                    A_CTRL:   ctrl_q       <= host_wdata;
                    default:  ;
                endcase
            end
        end
    end

    assign alarm_hit = chk_q && (time_q.sec == alarm_q.sec)
                             && (time_q.min == alarm_q.min)
                             && (time_q.hour == alarm_q.hour);

    always_comb begin
        flag_set         = '0;
        flag_set[F_UPD]  = chk_q;
        flag_set[F_ALM]  = alarm_hit;
    end

    assign flag_clr = host_rd && (addr_i == A_FLAGS);

    rtc_flags #(.N(N_FLAGS)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flags)
    );

    always_comb begin
        case (addr_i)
            A_SEC:    rd_mux = time_q.sec;
            A_SEC_AL: rd_mux = alarm_q.sec;
            A_MIN:    rd_mux = time_q.min;
            A_MIN_AL: rd_mux = alarm_q.min;
            A_HOUR:   rd_mux = time_q.hour;
            A_HR_AL:  rd_mux = alarm_q.hour;
            A_WDAY:   rd_mux = time_q.wday;
            A_MDAY:   rd_mux = time_q.mday;
            A_MON:    rd_mux = time_q.mon;
            A_YEAR:   rd_mux = time_q.year;
            A_STAT:   rd_mux = {upd_q, 7'd0};
            A_CTRL:   rd_mux = ctrl_q;
            A_FLAGS:  rd_mux = {2'b00, flags[F_ALM], flags[F_UPD], 4'd0};
            default:  rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          host_rdata <= 8'h00;
        else if (host_rd) host_rdata <= rd_mux;
    end

    assign irq_alarm  = flags[F_ALM] && ctrl_q[B_AL_EN];
    assign irq_update = flags[F_UPD] && ctrl_q[B_UP_EN];
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [7:0]        host_rdata,
    input logic [7:0]        ctrl,
    input logic              upd,
    input logic              chk,
    input logic [7:0]        sec,
    input logic              irq_alarm,
    input logic              irq_update
);
    AST_UIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd);                                                   // R7
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_rd && int'(host_addr) == 10) |=> (host_rdata[6:0] == 7'd0)); // R7
    AST_FREEZE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && ctrl[7] && !upd) |=> !upd);                         // R3
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!upd && !(host_wr && int'(host_addr) == 0)) |=> $stable(sec));  // R2
    AST_UPD_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (host_rd && int'(host_addr) == 12 && !chk) |=> !irq_update);     // R9
    AST_ALARM_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (host_rd && int'(host_addr) == 12 && !chk) |=> !irq_alarm);      // R10
endmodule

bind rtc_core rtc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_1hz   (tick_1hz),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .ctrl       (ctrl_q),
    .upd        (upd_q),
    .chk        (chk_q),
    .sec        (time_q.sec),
    .irq_alarm  (irq_alarm),
    .irq_update (irq_update)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_alarm, irq_update;

    int tests = 0;
    int fails = 0;
    logic rd_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    rtc_core #(.ADDR_W(4)) dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_alarm(irq_alarm), .irq_update(irq_update)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: compare read results against the scoreboard
    always @(posedge clk) rd_d <= host_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R2: actual unexpected read expected none");
            end else begin
                check(host_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // driver tasks: called at a falling edge, return at a falling edge
    task automatic wr(input int a, input logic [7:0] d);
        host_addr = 4'(a); host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        host_addr = 4'(a); host_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic tick();
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(11, 8'h02, "R1 ctrl");
        rd(0, 8'h00, "R1 sec");
        rd(4, 8'h00, "R1 hour");
        rd(6, 8'h01, "R1 wday");
        rd(7, 8'h01, "R1 mday");
        rd(8, 8'h01, "R1 mon");
        rd(12, 8'h00, "R1 flags");
        rd(10, 8'h00, "R1 status");
        check({6'd0, irq_alarm, irq_update}, 8'h00, "R1 irqs");

        // R3 freeze, then R2/R4/R5 full BCD rollover (non-leap Feb)
        wr(11, 8'h82);
        wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h23); wr(6, 8'h07);
        wr(7, 8'h28); wr(8, 8'h02); wr(9, 8'h23);
        tick();
        rd(0, 8'h59, "R3 frozen sec");
        rd(10, 8'h00, "R3 no uip");
        wr(11, 8'h02);
        tick();
        rd(0, 8'h00, "R4 sec wrap");
        rd(2, 8'h00, "R4 min wrap");
        rd(4, 8'h00, "R4 hour wrap");
        rd(6, 8'h01, "R4 wday wrap");
        rd(7, 8'h01, "R5 feb28 nonleap");
        rd(8, 8'h03, "R5 month carry");
        rd(9, 8'h23, "R5 year kept");
        rd(12, 8'h30, "R10 alarm at zero");

        // R5 leap February
        wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h23);
        wr(7, 8'h28); wr(8, 8'h02); wr(9, 8'h24);
        tick();
        rd(7, 8'h29, "R5 leap day29");
        rd(8, 8'h02, "R5 leap month");
        wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h23);
        tick();
        rd(7, 8'h01, "R5 leap day1");
        rd(8, 8'h03, "R5 leap march");

        // R6 binary mode: year wrap, 30-day month, seconds encoding
        wr(11, 8'h86);
        wr(0, 8'd59); wr(2, 8'd59); wr(4, 8'd23);
        wr(7, 8'd31); wr(8, 8'd12); wr(9, 8'd99);
        wr(11, 8'h06);
        tick();
        rd(7, 8'd1, "R5 dec31 day");
        rd(8, 8'd1, "R5 dec31 month");
        rd(9, 8'd0, "R5 year 99 wrap");
        wr(0, 8'd59); wr(2, 8'd59); wr(4, 8'd23); wr(7, 8'd30); wr(8, 8'd4);
        tick();
        rd(7, 8'd1, "R5 apr30 day");
        rd(8, 8'd5, "R5 apr30 month");
        wr(0, 8'd9);
        tick();
        rd(0, 8'h0A, "R6 binary sec");

        // R8 12-hour BCD and binary
        wr(11, 8'h00);
        wr(0, 8'h09);
        tick();
        rd(0, 8'h10, "R6 bcd sec");
        wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h11);
        tick();
        rd(4, 8'h92, "R8 11am to 12pm");
        wr(0, 8'h59); wr(2, 8'h59);
        tick();
        rd(4, 8'h81, "R8 12pm to 1pm");
        wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h91);
        tick();
        rd(4, 8'h12, "R8 11pm to 12am");
        wr(11, 8'h04);
        wr(0, 8'd59); wr(2, 8'd59); wr(4, 8'h8B);
        tick();
        rd(4, 8'h0C, "R8 binary 12am");

        // R10 alarm with interrupt enable, R9 gating
        wr(11, 8'h22);
        wr(1, 8'h31); wr(3, 8'h20); wr(5, 8'h10);
        wr(0, 8'h30); wr(2, 8'h20); wr(4, 8'h10);
        rd(12, 8'h30, "R10 flags before");
        tick();
        check({7'd0, irq_alarm}, 8'h01, "R10 irq_alarm set");
        check({7'd0, irq_update}, 8'h00, "R9 irq_update gated");
        rd(12, 8'h30, "R10 alarm flag");
        check({7'd0, irq_alarm}, 8'h00, "R10 irq_alarm cleared");
        rd(12, 8'h00, "R10 read clears");
        tick();
        rd(12, 8'h10, "R10 no match");

        // R9 update interrupt
        wr(11, 8'h12);
        tick();
        check({7'd0, irq_update}, 8'h01, "R9 irq_update set");
        rd(12, 8'h10, "R9 update flag");
        check({7'd0, irq_update}, 8'h00, "R9 irq_update cleared");

        // R7 update-in-progress and read-only status
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        rd(10, 8'h80, "R7 uip high");
        repeat (2) @(negedge clk);
        rd(10, 8'h00, "R7 uip low");
        wr(10, 8'h7F);
        rd(10, 8'h00, "R7 status write ignored");
        rd(12, 8'h10, "R9 clear before race");

        // R9 read-clear and flag set in the same cycle
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        @(negedge clk);
        rd(12, 8'h00, "R9 race old value");
        rd(12, 8'h10, "R9 race set wins");

        // R11 host write during update apply
        wr(0, 8'h59); wr(2, 8'h10);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        wr(0, 8'h45);
        repeat (3) @(negedge clk);
        rd(0, 8'h45, "R11 write wins");
        rd(2, 8'h11, "R11 carry kept");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule